// File: doc/BRIEF.md
# Video PLL control register bank

This block holds the configuration of a video clock generator and presents it to the analog loop as parallel outputs. A serial-bus controller reaches it through a simple byte-wide register port. The port has a write strobe, a read strobe, an 8-bit address, 8-bit write data and registered 8-bit read data. The configuration covers a 12-bit feedback divider setting, a VCO band field, a charge-pump current code and a 5-bit sampling phase. A fixed revision byte is also readable.

The divider setting is spread over two addresses. A write to the high byte only stages it. The active divider changes when the low nibble is written, and the new value joins the staged high byte with that nibble in one step. A committed setting below the lowest usable value is raised to that value, and the event is latched in a sticky flag. Software reads and clears that flag through the low-nibble address.

Top module: `vpll_regs_top`

## Requirements
- R1: After reset, the active divider setting is 1693, so `div_ratio` reads 1694. The band is 01, the pump code is 001, the phase is 16, `post_div` is 2 and the range-error flag is clear.
- R2: Address 0x00 reads back the `REVISION` parameter (default 0x1A). Writes to 0x00 and to any address above 0x04 change no output and no readable register.
- R3: A write to 0x01 stores wdata[7:0] as the staged high byte and leaves `div_ratio` unchanged. Reading 0x01 returns the staged byte.
- R4: A write to 0x02 makes the active setting {staged high byte, wdata[7:4]} on the following clock edge. `div_ratio` always equals the active setting plus one, across the full range up to 4096.
- R5: If a committed setting is below 221, the active setting becomes 221 and the range-error flag is set. A commit of exactly 221 or more leaves the flag unchanged.
- R6: Reading 0x02 returns {active setting[3:0], 3'b000, range-error flag}. The same read clears the flag, so the next read shows it clear.
- R7: A write to 0x03 stores wdata[7:6] as the band and wdata[5:3] as the pump code. Reading 0x03 returns {band, pump, 3'b000}.
- R8: `post_div` is 4 for band 00, 2 for band 01, and 1 for band 10 and for the reserved code 11.
- R9: A write to 0x04 stores wdata[7:3] as the phase. Reading 0x04 returns {phase, 3'b000}.
- R10: `rdata` takes the addressed value one clock edge after `rd_en` is sampled high and holds it otherwise. Unmapped addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| div_ratio | output | 13 | Active feedback divide ratio (setting + 1) |
| vco_band | output | 2 | VCO band select |
| post_div | output | 3 | Post-divider factor (4, 2 or 1) |
| pump_code | output | 3 | Charge-pump current code |
| phase | output | 5 | Sampling phase step |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. Under that assumption, a read of 0x02 and a commit never coincide, so the clear-on-read property and the clamp-flag property cannot fight each other. The bench drives each access as a single-cycle strobe on the falling edge and returns both strobes to zero before starting the next access. Divider commits are always preceded by a separate high-byte write, so the staged value in use is known.

// File: rtl/vpll_pkg.sv
package vpll_pkg;

    localparam int DIV_W  = 12;
    localparam int HI_W   = 8;
    localparam int LO_W   = DIV_W - HI_W;
    localparam int PUMP_W = 3;
    localparam int PH_W   = 5;

    localparam logic [7:0] ADDR_REV    = 8'h00;
    localparam logic [7:0] ADDR_DIV_HI = 8'h01;
    localparam logic [7:0] ADDR_DIV_LO = 8'h02;
    localparam logic [7:0] ADDR_CTRL   = 8'h03;
    localparam logic [7:0] ADDR_PHASE  = 8'h04;

    localparam logic [DIV_W-1:0] DIV_RESET = 12'd1693;
    localparam logic [DIV_W-1:0] DIV_MIN   = 12'd221;

    typedef enum logic [1:0] {
        BAND_LOW  = 2'b00,
        BAND_MID  = 2'b01,
        BAND_HIGH = 2'b10,
        BAND_RSVD = 2'b11
    } band_e;

    typedef struct packed {
        band_e             band;
        logic [PUMP_W-1:0] pump;
        logic [PH_W-1:0]   phase;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{band: BAND_MID, pump: 3'b001, phase: 5'd16};

    function automatic logic [2:0] post_div_of(band_e b);
        case (b)
            BAND_LOW: return 3'd4;
            BAND_MID: return 3'd2;
            default:  return 3'd1;
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] floor_div(logic [DIV_W-1:0] v);
        return (v < DIV_MIN) ? DIV_MIN : v;
    endfunction

endpackage

// File: rtl/vpll_div_stage.sv
module vpll_div_stage
    import vpll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic             err_clr,
    input  logic [7:0]       wdata,
    output logic [HI_W-1:0]  staged_hi,
    output logic [DIV_W-1:0] active,
    output logic             range_err
);

    logic [HI_W-1:0]  staged_q;
    logic [DIV_W-1:0] active_q;
    logic             err_q;
    logic [DIV_W-1:0] candidate;
    logic             too_low;

    assign candidate = {staged_q, wdata[7:8-LO_W]};
    assign too_low   = candidate < DIV_MIN;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= DIV_RESET[DIV_W-1:LO_W];
            active_q <= DIV_RESET;
            err_q    <= 1'b0;
        end else begin
            if (hi_we)
                staged_q <= wdata[HI_W-1:0];
            if (lo_we)
                active_q <= floor_div(candidate);
            if (lo_we && too_low)
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;
        end
    end

    assign staged_hi = staged_q;
    assign active    = active_q;
    assign range_err = err_q;

    a_r3_stage_only: assert property (@(posedge clk) disable iff (rst)
        (hi_we && !lo_we) |=> $stable(active));
    a_r4_commit: assert property (@(posedge clk) disable iff (rst)
        (lo_we && !too_low) |=> (active == $past(candidate)));
    a_r5_floor: assert property (@(posedge clk) disable iff (rst)
        active >= DIV_MIN);
    a_r5_flag_on_clamp: assert property (@(posedge clk) disable iff (rst)
        (lo_we && too_low) |=> (range_err && active == DIV_MIN));
    a_r6_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !lo_we) |=> !range_err);

endmodule

// File: rtl/vpll_cfg_fields.sv
module vpll_cfg_fields
    import vpll_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctrl_we,
    input  logic     phase_we,
    input  logic [7:0] wdata,
    output clk_cfg_t cfg
);

    clk_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            if (ctrl_we) begin
                cfg_q.band <= band_e'(wdata[7:6]);
                cfg_q.pump <= wdata[5:6-PUMP_W];
            end
            if (phase_we)
                cfg_q.phase <= wdata[7:8-PH_W];
        end
    end

    assign cfg = cfg_q;

    a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> ($stable(cfg.band) && $stable(cfg.pump)));
    a_r9_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !phase_we |=> $stable(cfg.phase));

endmodule

// File: rtl/vpll_regs_top.sv
module vpll_regs_top
    import vpll_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'h1A
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [12:0] div_ratio,
    output logic [1:0]  vco_band,
    output logic [2:0]  post_div,
    output logic [2:0]  pump_code,
    output logic [4:0]  phase
);

    logic [HI_W-1:0]  staged_hi;
    logic [DIV_W-1:0] active;
    logic             range_err;
    clk_cfg_t         cfg;
    logic [7:0]       rd_mux;
    logic [7:0]       rdata_q;

    vpll_div_stage u_div (
        .clk       (clk),
        .rst       (rst),
        .hi_we     (wr_en && addr == ADDR_DIV_HI),
        .lo_we     (wr_en && addr == ADDR_DIV_LO),
        .err_clr   (rd_en && addr == ADDR_DIV_LO),
        .wdata     (wdata),
        .staged_hi (staged_hi),
        .active    (active),
        .range_err (range_err)
    );

    vpll_cfg_fields u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (wr_en && addr == ADDR_CTRL),
        .phase_we (wr_en && addr == ADDR_PHASE),
        .wdata    (wdata),
        .cfg      (cfg)
    );

    always_comb begin
        case (addr)
            ADDR_REV:    rd_mux = REVISION;
            ADDR_DIV_HI: rd_mux = staged_hi;
            ADDR_DIV_LO: rd_mux = {active[LO_W-1:0], 3'b000, range_err};
            ADDR_CTRL:   rd_mux = {cfg.band, cfg.pump, 3'b000};
            ADDR_PHASE:  rd_mux = {cfg.phase, 3'b000};
            default:     rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= 8'h00;
        else if (rd_en)
            rdata_q <= rd_mux;
    end

    assign rdata     = rdata_q;
    assign div_ratio = {1'b0, active} + 13'd1;
    assign vco_band  = cfg.band;
    assign post_div  = post_div_of(cfg.band);
    assign pump_code = cfg.pump;
    assign phase     = cfg.phase;

    a_r8_post_div_single: assert property (@(posedge clk) disable iff (rst)
        $countones(post_div) == 1);
    a_r8_low_band_div4: assert property (@(posedge clk) disable iff (rst)
        (vco_band == 2'b00) |-> (post_div == 3'd4));
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
    a_r4_ratio_floor: assert property (@(posedge clk) disable iff (rst)
        div_ratio > 13'd221);

endmodule

// File: tb/vpll_regs_top_test.sv
module vpll_regs_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [12:0] div_ratio;
    logic [1:0]  vco_band;
    logic [2:0]  post_div;
    logic [2:0]  pump_code;
    logic [4:0]  phase;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;
    logic [7:0] last_rd = 8'h00;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    vpll_regs_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .div_ratio(div_ratio), .vco_band(vco_band),
        .post_div(post_div), .pump_code(pump_code), .phase(phase)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("monitor queue empty", 16'd1, 16'd0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {8'h00, rdata}, {8'h00, e});
                last_rd = rdata;
            end
        end
    end

    task automatic check_outs(string tag, int ratio, int band, int pd, int pump, int ph);
        check({tag, " ratio"}, 16'(div_ratio), 16'(ratio));
        check({tag, " band"},  16'(vco_band),  16'(band));
        check({tag, " postdiv"}, 16'(post_div), 16'(pd));
        check({tag, " pump"},  16'(pump_code), 16'(pump));
        check({tag, " phase"}, 16'(phase),     16'(ph));
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            check("watchdog", 16'd1, 16'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_outs("R1 reset", 1694, 1, 2, 1, 16);
        rd(8'h02, 8'hD0, "R1 reset flag clear / R6 layout");
        rd(8'h00, 8'h1A, "R2 revision");
        rd(8'h01, 8'h69, "R3 reset staged byte");
        rd(8'h03, 8'h48, "R7 reset ctrl readback");
        rd(8'h04, 8'h80, "R9 reset phase readback");
        rd(8'h05, 8'h00, "R10 unmapped read");
        // R10: rdata holds without rd_en
        repeat (2) @(negedge clk);
        check("R10 rdata hold", 16'(rdata), 16'(last_rd));

        // R3: staging only
        wr(8'h01, 8'h80);
        @(negedge clk);
        check("R3 staged write leaves ratio", 16'(div_ratio), 16'd1694);
        rd(8'h01, 8'h80, "R3 staged readback");

        // R4: commit
        wr(8'h02, 8'h3F);
        check("R4 commit 0x803", 16'(div_ratio), 16'd2052);
        rd(8'h02, 8'h30, "R4 low nibble readback");
        wr(8'h01, 8'hFF);
        wr(8'h02, 8'hF0);
        check("R4 max setting", 16'(div_ratio), 16'd4096);

        // R5 clamp: 0x0DC = 220
        wr(8'h01, 8'h0D);
        wr(8'h02, 8'hC0);
        check("R5 clamp to 221", 16'(div_ratio), 16'd222);
        rd(8'h02, 8'hD1, "R6 flag set read");
        rd(8'h02, 8'hD0, "R6 flag cleared after read");
        // R5 boundary 221
        wr(8'h01, 8'h0D);
        wr(8'h02, 8'hD0);
        check("R5 exact 221", 16'(div_ratio), 16'd222);
        rd(8'h02, 8'hD0, "R5 no flag at 221");

        // R7 / R8
        wr(8'h03, 8'h07);
        check_outs("R8 band00", 222, 0, 4, 0, 16);
        rd(8'h03, 8'h00, "R7 ctrl unused bits zero");
        wr(8'h03, 8'hBF);
        check_outs("R8 band10", 222, 2, 1, 7, 16);
        rd(8'h03, 8'hB8, "R7 ctrl readback");
        wr(8'h03, 8'hC0);
        check_outs("R8 band11", 222, 3, 1, 0, 16);
        wr(8'h03, 8'h50);
        check_outs("R8 band01", 222, 1, 2, 2, 16);

        // R9
        wr(8'h04, 8'hFF);
        check("R9 phase max", 16'(phase), 16'd31);
        rd(8'h04, 8'hF8, "R9 phase readback");
        wr(8'h04, 8'h07);
        check("R9 phase zero", 16'(phase), 16'd0);

        // R2: ignored writes
        wr(8'h00, 8'h55);
        wr(8'h07, 8'hAA);
        wr(8'hFF, 8'hFF);
        check_outs("R2 ignored writes", 222, 1, 2, 2, 0);
        rd(8'h00, 8'h1A, "R2 revision after write");
        rd(8'h01, 8'h0D, "R2 staged untouched");
        rd(8'h07, 8'h00, "R2 unmapped still zero");

        repeat (2) @(negedge clk);
        check("scoreboard drained", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule